// File: doc/BRIEF.md
# Snooping Write-Invalidate Coherence Controller

This block keeps the coherence state of a small group of cache lines for one core on a shared snooping bus. Each tracked line is named by a line index; the block holds no data and no tags beyond that index. On the processor side it takes load and store requests, one at a time. Each request either completes locally or makes the block request one bus transaction and stall the core until that transaction is granted. On the bus side it watches transactions issued by other cores. It updates the local line state from them, drives a shared response and pulses a write-back when it holds dirty data that another core needs.

A parameter selects the protocol. With `MESI_EN = 0` the lines move between Invalid, Shared and Modified. With `MESI_EN = 1` a read fill that no other cache answers gives the Exclusive state. A later store to an Exclusive line then upgrades it to Modified without any bus traffic. Arbitration, memory and the peer caches live outside the block.

Top module: `coh_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `cpu_busy`, `cpu_done`, `bus_req`, `snp_shared_out` and `wb_valid` are low.
- R2: A load to an Invalid line raises `bus_req` with `bus_cmd` = 1 (read) and `bus_line` set to the requested line, two cycles after the request is sampled. `cpu_busy` stays high until the grant, and `cpu_done` pulses in the cycle after the grant is sampled.
- R3: The state reported in `cpu_rsp_state` uses the encoding Invalid = 0, Shared = 1, Exclusive = 2, Modified = 3. After a read fill the state is Shared when `MESI_EN` = 0, or when `bus_shared_in` is high at the grant; otherwise it is Exclusive.
- R4: A store to an Invalid or Shared line requests `bus_cmd` = 2 (read-for-ownership), and the line becomes Modified when the grant arrives.
- R5: A store to an Exclusive line makes no bus request. It completes with `cpu_done` two cycles after the request, and the line becomes Modified.
- R6: A load to a Shared, Exclusive or Modified line, and a store to a Modified line, make no bus request and leave the state unchanged.
- R7: A snooped read (`snp_cmd` = 1) of a Modified line pulses `wb_valid` with `wb_line` in the next cycle, and the line becomes Shared.
- R8: A snooped read-for-ownership (`snp_cmd` = 2) makes any line Invalid. If the line was Modified, `wb_valid` pulses with `wb_line` in the next cycle.
- R9: In the cycle after a snooped read, `snp_shared_out` is high exactly when the line was valid. An Exclusive line that sees the read becomes Shared.
- R10: While `bus_req` is high without a grant, `bus_cmd` and `bus_line` hold steady. `bus_req` falls in the cycle after a grant, so each grant carries one transaction.
- R11: A request made while `cpu_busy` is high is ignored.
- R12: If a snoop of the requested line arrives in the cycle the request is decided, the decision waits one cycle and then uses the state the snoop left.
- R13: A snooped write-back (`snp_cmd` = 3) changes no line state and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | One-cycle request pulse from the core |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_line | input | LINE_W | Line index of the request |
| cpu_busy | output | 1 | Request in progress |
| cpu_done | output | 1 | Request completed (one-cycle pulse) |
| cpu_rsp_state | output | 2 | Line state after the completed request |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | 1 read, 2 read-for-ownership |
| bus_line | output | LINE_W | Line index of the bus transaction |
| bus_gnt | input | 1 | Grant of the requested transaction |
| bus_shared_in | input | 1 | Another cache holds the line, sampled at grant |
| snp_valid | input | 1 | Transaction from another core is on the bus |
| snp_cmd | input | 2 | 1 read, 2 read-for-ownership, 3 write-back |
| snp_line | input | LINE_W | Line index of the snooped transaction |
| snp_shared_out | output | 1 | This cache held the line during a snooped read |
| wb_valid | output | 1 | Dirty data write-back pulse |
| wb_line | output | LINE_W | Line index of the write-back |

## Verification
The hardest case is a snoop that lands on the line a pending request is about to decide on. The silent upgrade from Exclusive must not happen once another core has read the line. The bench fills a line to Exclusive, pulses a store, and puts a snooped read of the same line on the bus exactly one cycle later. It then expects a read-for-ownership rather than a silent upgrade. Reaching this needs cycle-exact timing from the core side together with control of the snoop inputs, which a random traffic pattern rarely hits.

// File: rtl/coh_pkg.sv
package coh_pkg;
  localparam logic [1:0] ST_I = 2'd0;
  localparam logic [1:0] ST_S = 2'd1;
  localparam logic [1:0] ST_E = 2'd2;
  localparam logic [1:0] ST_M = 2'd3;

  localparam logic [1:0] CMD_NONE = 2'd0;
  localparam logic [1:0] CMD_RD   = 2'd1;
  localparam logic [1:0] CMD_RDX  = 2'd2;
  localparam logic [1:0] CMD_WB   = 2'd3;

  typedef enum logic [1:0] {FS_IDLE, FS_DECIDE, FS_WAIT} req_fs_t;
endpackage

// File: rtl/coh_line.sv
module coh_line
  import coh_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       upd_en,
  input  logic [1:0] upd_state,
  input  logic       snp_en,
  input  logic [1:0] snp_cmd,
  output logic [1:0] state
);
  // local updates (fill or hit) take priority over snoops
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_I;
    end else if (upd_en) begin
      state <= upd_state;
    end else if (snp_en) begin
      case (snp_cmd)
        CMD_RD:  if (state == ST_M || state == ST_E) state <= ST_S;
        CMD_RDX: state <= ST_I;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
  import coh_pkg::*;
#(
  parameter int LINE_W  = 2,
  parameter bit MESI_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [LINE_W-1:0] cpu_line,
  input  logic [1:0]        cur_state,
  input  logic              snp_collide,
  input  logic              bus_gnt,
  input  logic              bus_shared_in,
  output logic [LINE_W-1:0] pend_line,
  output logic              upd_en,
  output logic [1:0]        upd_state,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic              cpu_busy,
  output logic              cpu_done,
  output logic [1:0]        rsp_state
);
  req_fs_t    fs;
  logic       pend_we;
  logic       need_bus;
  logic [1:0] hit_state;
  logic [1:0] miss_cmd;
  logic [1:0] rd_fill;
  logic [1:0] fill_state;

  generate
    if (MESI_EN) begin : g_mesi
      assign rd_fill = bus_shared_in ? ST_S : ST_E;
    end else begin : g_msi
      assign rd_fill = ST_S;
    end
  endgenerate

  always_comb begin
    need_bus   = pend_we ? (cur_state == ST_I || cur_state == ST_S)
                         : (cur_state == ST_I);
    hit_state  = pend_we ? ST_M : cur_state;
    miss_cmd   = pend_we ? CMD_RDX : CMD_RD;
    fill_state = (bus_cmd == CMD_RDX) ? ST_M : rd_fill;
    upd_en     = (fs == FS_DECIDE && !snp_collide && !need_bus) ||
                 (fs == FS_WAIT && bus_gnt);
    upd_state  = (fs == FS_WAIT) ? fill_state : hit_state;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fs        <= FS_IDLE;
      pend_we   <= 1'b0;
      pend_line <= '0;
      bus_req   <= 1'b0;
      bus_cmd   <= CMD_NONE;
      cpu_busy  <= 1'b0;
      cpu_done  <= 1'b0;
      rsp_state <= ST_I;
    end else begin
      cpu_done <= 1'b0;
      case (fs)
        FS_IDLE: if (cpu_req) begin
          pend_we   <= cpu_we;
          pend_line <= cpu_line;
          cpu_busy  <= 1'b1;
          fs        <= FS_DECIDE;
        end
        FS_DECIDE: if (!snp_collide) begin
          if (need_bus) begin
            bus_req <= 1'b1;
            bus_cmd <= miss_cmd;
            fs      <= FS_WAIT;
          end else begin
            cpu_done  <= 1'b1;
            rsp_state <= hit_state;
            cpu_busy  <= 1'b0;
            fs        <= FS_IDLE;
          end
        end
        FS_WAIT: if (bus_gnt) begin
          bus_req   <= 1'b0;
          bus_cmd   <= CMD_NONE;
          cpu_done  <= 1'b1;
          rsp_state <= fill_state;
          cpu_busy  <= 1'b0;
          fs        <= FS_IDLE;
        end
        default: fs <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
  import coh_pkg::*;
#(
  parameter int LINE_W  = 2,
  parameter bit MESI_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [LINE_W-1:0] cpu_line,
  output logic              cpu_busy,
  output logic              cpu_done,
  output logic [1:0]        cpu_rsp_state,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [LINE_W-1:0] bus_line,
  input  logic              bus_gnt,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [LINE_W-1:0] snp_line,
  output logic              snp_shared_out,
  output logic              wb_valid,
  output logic [LINE_W-1:0] wb_line
);
  localparam int NUM_LINES = 1 << LINE_W;

  logic [1:0]        st [NUM_LINES];
  logic [LINE_W-1:0] pend_line;
  logic              upd_en;
  logic [1:0]        upd_state;
  logic [1:0]        cur_state;
  logic [1:0]        snp_state;
  logic              snp_act;
  logic              snp_collide;

  assign cur_state   = st[pend_line];
  assign snp_state   = st[snp_line];
  assign snp_act     = snp_valid && (snp_cmd == CMD_RD || snp_cmd == CMD_RDX);
  assign snp_collide = snp_act && (snp_line == pend_line);
  assign bus_line    = pend_line;

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      coh_line u_line (
        .clk       (clk),
        .rst       (rst),
        .upd_en    (upd_en && pend_line == LINE_W'(i)),
        .upd_state (upd_state),
        .snp_en    (snp_valid && snp_line == LINE_W'(i)),
        .snp_cmd   (snp_cmd),
        .state     (st[i])
      );
    end
  endgenerate

  coh_req_fsm #(.LINE_W(LINE_W), .MESI_EN(MESI_EN)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .cpu_req       (cpu_req),
    .cpu_we        (cpu_we),
    .cpu_line      (cpu_line),
    .cur_state     (cur_state),
    .snp_collide   (snp_collide),
    .bus_gnt       (bus_gnt),
    .bus_shared_in (bus_shared_in),
    .pend_line     (pend_line),
    .upd_en        (upd_en),
    .upd_state     (upd_state),
    .bus_req       (bus_req),
    .bus_cmd       (bus_cmd),
    .cpu_busy      (cpu_busy),
    .cpu_done      (cpu_done),
    .rsp_state     (cpu_rsp_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      snp_shared_out <= 1'b0;
      wb_valid       <= 1'b0;
      wb_line        <= '0;
    end else begin
      snp_shared_out <= snp_valid && snp_cmd == CMD_RD && snp_state != ST_I;
      wb_valid       <= snp_act && snp_state == ST_M;
      wb_line        <= snp_line;
    end
  end
endmodule

// File: rtl/coh_ctrl_chk.sv
module coh_ctrl_chk
  import coh_pkg::*;
#(
  parameter int LINE_W  = 2,
  parameter bit MESI_EN = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_busy,
  input logic              cpu_done,
  input logic [1:0]        cpu_rsp_state,
  input logic              bus_req,
  input logic [1:0]        bus_cmd,
  input logic [LINE_W-1:0] bus_line,
  input logic              bus_gnt,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic              wb_valid
);
  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_cmd) && $stable(bus_line));
  // R10
  bus_drop_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_gnt |=> !bus_req);
  // R2
  busy_while_req_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> cpu_busy);
  // R2
  done_after_gnt_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_gnt |=> cpu_done);
  // R3
  msi_no_excl_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_done && !MESI_EN |-> cpu_rsp_state != ST_E);
  // R8
  wb_from_snoop_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(snp_valid && (snp_cmd == CMD_RD || snp_cmd == CMD_RDX)));
  // R2
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> !cpu_busy);
endmodule

bind coh_ctrl coh_ctrl_chk #(.LINE_W(LINE_W), .MESI_EN(MESI_EN)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cpu_busy      (cpu_busy),
  .cpu_done      (cpu_done),
  .cpu_rsp_state (cpu_rsp_state),
  .bus_req       (bus_req),
  .bus_cmd       (bus_cmd),
  .bus_line      (bus_line),
  .bus_gnt       (bus_gnt),
  .snp_valid     (snp_valid),
  .snp_cmd       (snp_cmd),
  .wb_valid      (wb_valid)
);

// File: tb/coh_ctrl_test.sv
module coh_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 2;
  localparam int NV = 19;

  // vector: op[11:9] line[8:7] shin[6] ecmd[5:4] est[3:2] esh[1] ewb[0]
  // op: 0 load, 1 store, 2 snoop read, 3 snoop rfo, 4 snoop write-back
  localparam logic [11:0] VEC [NV] = '{
    {3'd0, 2'd0, 1'b0, 2'd1, 2'd2, 1'b0, 1'b0},  // R2 R3 load I -> E
    {3'd0, 2'd0, 1'b0, 2'd0, 2'd2, 1'b0, 1'b0},  // R6 load hit E
    {3'd1, 2'd0, 1'b0, 2'd0, 2'd3, 1'b0, 1'b0},  // R5 store E -> M silent
    {3'd2, 2'd0, 1'b0, 2'd0, 2'd0, 1'b1, 1'b1},  // R7 snoop read of M
    {3'd0, 2'd0, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0},  // R6 load hit S
    {3'd1, 2'd0, 1'b0, 2'd2, 2'd3, 1'b0, 1'b0},  // R4 store S -> M
    {3'd3, 2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1},  // R8 rfo on M
    {3'd0, 2'd1, 1'b1, 2'd1, 2'd1, 1'b0, 1'b0},  // R3 fill shared -> S
    {3'd2, 2'd1, 1'b0, 2'd0, 2'd0, 1'b1, 1'b0},  // R9 snoop read of S
    {3'd1, 2'd1, 1'b0, 2'd2, 2'd3, 1'b0, 1'b0},  // R4 store S
    {3'd4, 2'd1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0},  // R13 snooped write-back
    {3'd1, 2'd1, 1'b0, 2'd0, 2'd3, 1'b0, 1'b0},  // R6 R13 store still hits M
    {3'd2, 2'd2, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0},  // R9 snoop read of I
    {3'd0, 2'd2, 1'b0, 2'd1, 2'd2, 1'b0, 1'b0},  // R3 fill -> E
    {3'd2, 2'd2, 1'b0, 2'd0, 2'd0, 1'b1, 1'b0},  // R9 E -> S
    {3'd1, 2'd2, 1'b0, 2'd2, 2'd3, 1'b0, 1'b0},  // R9 R4 store after E->S
    {3'd1, 2'd3, 1'b0, 2'd2, 2'd3, 1'b0, 1'b0},  // R4 store I
    {3'd3, 2'd3, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1},  // R8 rfo on M
    {3'd3, 2'd1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1}   // R8 rfo on M
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [LW-1:0] cpu_line = '0;
  logic cpu_busy, cpu_done, bus_req, snp_shared_out, wb_valid;
  logic [1:0] cpu_rsp_state, bus_cmd;
  logic [LW-1:0] bus_line, wb_line;
  logic bus_gnt = 1'b0, bus_shared_in = 1'b0, snp_valid = 1'b0;
  logic [1:0] snp_cmd = 2'd0;
  logic [LW-1:0] snp_line = '0;

  logic m_req = 1'b0, m_we = 1'b0, m_gnt = 1'b0;
  logic [LW-1:0] m_line = '0;
  logic m_busy, m_done, m_bus_req, m_sh, m_wb;
  logic [1:0] m_rsp, m_cmd;
  logic [LW-1:0] m_bline, m_wbline;

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coh_ctrl #(.LINE_W(LW), .MESI_EN(1'b1)) uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_line(cpu_line),
    .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rsp_state(cpu_rsp_state),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_line(bus_line), .bus_gnt(bus_gnt),
    .bus_shared_in(bus_shared_in), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_line(snp_line), .snp_shared_out(snp_shared_out), .wb_valid(wb_valid),
    .wb_line(wb_line));

  coh_ctrl #(.LINE_W(LW), .MESI_EN(1'b0)) uut_msi (
    .clk(clk), .rst(rst), .cpu_req(m_req), .cpu_we(m_we), .cpu_line(m_line),
    .cpu_busy(m_busy), .cpu_done(m_done), .cpu_rsp_state(m_rsp),
    .bus_req(m_bus_req), .bus_cmd(m_cmd), .bus_line(m_bline), .bus_gnt(m_gnt),
    .bus_shared_in(1'b0), .snp_valid(1'b0), .snp_cmd(2'd0), .snp_line('0),
    .snp_shared_out(m_sh), .wb_valid(m_wb), .wb_line(m_wbline));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_cpu(input logic we, input logic [LW-1:0] line, input logic shin,
                        input logic [1:0] ecmd, input logic [1:0] est, input string tag);
    @(negedge clk); cpu_req = 1'b1; cpu_we = we; cpu_line = line;
    @(negedge clk); cpu_req = 1'b0;
    @(negedge clk);
    if (ecmd == 2'd0) begin
      check(cpu_done && !bus_req, tag, {bus_req, cpu_done}, 1);
      check(cpu_rsp_state == est, tag, cpu_rsp_state, est);
    end else begin
      check(bus_req && bus_cmd == ecmd && bus_line == line, tag,
            {bus_req, bus_cmd, bus_line}, {1'b1, ecmd, line});
      @(negedge clk);
      // R10 stall without grant
      check(bus_req && cpu_busy && !cpu_done && bus_cmd == ecmd, "R10",
            {bus_req, cpu_busy, cpu_done}, 6);
      bus_gnt = 1'b1; bus_shared_in = shin;
      @(negedge clk); bus_gnt = 1'b0; bus_shared_in = 1'b0;
      check(cpu_done && !bus_req && !cpu_busy, tag, {cpu_done, bus_req, cpu_busy}, 4);
      check(cpu_rsp_state == est, tag, cpu_rsp_state, est);
    end
  endtask

  task automatic do_snoop(input logic [1:0] cmd, input logic [LW-1:0] line,
                          input logic esh, input logic ewb, input string tag);
    @(negedge clk); snp_valid = 1'b1; snp_cmd = cmd; snp_line = line;
    @(negedge clk); snp_valid = 1'b0; snp_cmd = 2'd0;
    check(snp_shared_out == esh, tag, snp_shared_out, esh);
    check(wb_valid == ewb && (!ewb || wb_line == line), tag,
          {wb_valid, wb_line}, {ewb, line});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!cpu_busy && !cpu_done && !bus_req && !snp_shared_out && !wb_valid, "R1",
          {cpu_busy, cpu_done, bus_req, snp_shared_out, wb_valid}, 0);
    do_snoop(2'd1, 2'd3, 1'b0, 1'b0, "R1");

    for (int i = 0; i < NV; i++) begin
      logic [11:0] v;
      v = VEC[i];
      case (v[11:9])
        3'd0:    do_cpu(1'b0, v[8:7], v[6], v[5:4], v[3:2], $sformatf("vec%0d R2-R6", i));
        3'd1:    do_cpu(1'b1, v[8:7], v[6], v[5:4], v[3:2], $sformatf("vec%0d R4-R6", i));
        3'd2:    do_snoop(2'd1, v[8:7], v[1], v[0], $sformatf("vec%0d R7/R9", i));
        3'd3:    do_snoop(2'd2, v[8:7], v[1], v[0], $sformatf("vec%0d R8", i));
        default: do_snoop(2'd3, v[8:7], v[1], v[0], $sformatf("vec%0d R13", i));
      endcase
    end

    // R11: request during busy ignored (line 0 is I, line 1 is I)
    @(negedge clk); cpu_req = 1'b1; cpu_we = 1'b0; cpu_line = 2'd0;
    @(negedge clk); cpu_req = 1'b0;
    @(negedge clk);
    check(bus_req && bus_cmd == 2'd1, "R11", bus_cmd, 1);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_line = 2'd1;
    @(negedge clk); cpu_req = 1'b0; bus_gnt = 1'b1;
    @(negedge clk); bus_gnt = 1'b0;
    check(cpu_done && cpu_rsp_state == 2'd2, "R11", cpu_rsp_state, 2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!bus_req && !cpu_done && !cpu_busy, "R11", {bus_req, cpu_done, cpu_busy}, 0);
    end

    // R12: snoop read collides with store decision on an Exclusive line
    do_cpu(1'b0, 2'd3, 1'b0, 2'd1, 2'd2, "R12 setup");
    @(negedge clk); cpu_req = 1'b1; cpu_we = 1'b1; cpu_line = 2'd3;
    @(negedge clk); cpu_req = 1'b0; snp_valid = 1'b1; snp_cmd = 2'd1; snp_line = 2'd3;
    @(negedge clk); snp_valid = 1'b0; snp_cmd = 2'd0;
    check(snp_shared_out && !bus_req && !cpu_done, "R12",
          {snp_shared_out, bus_req, cpu_done}, 4);
    @(negedge clk);
    check(bus_req && bus_cmd == 2'd2 && bus_line == 2'd3, "R12", bus_cmd, 2);
    bus_gnt = 1'b1;
    @(negedge clk); bus_gnt = 1'b0;
    check(cpu_done && cpu_rsp_state == 2'd3, "R12", cpu_rsp_state, 3);

    // R3: MSI variant fills to Shared without sharers
    @(negedge clk); m_req = 1'b1; m_we = 1'b0; m_line = 2'd0;
    @(negedge clk); m_req = 1'b0;
    @(negedge clk);
    check(m_bus_req && m_cmd == 2'd1, "R3", m_cmd, 1);
    m_gnt = 1'b1;
    @(negedge clk); m_gnt = 1'b0;
    check(m_done && m_rsp == 2'd1, "R3", m_rsp, 1);
    @(negedge clk); m_req = 1'b1; m_we = 1'b1;
    @(negedge clk); m_req = 1'b0;
    @(negedge clk);
    check(m_bus_req && m_cmd == 2'd2, "R3 R4", m_cmd, 2);
    m_gnt = 1'b1;
    @(negedge clk); m_gnt = 1'b0;
    check(m_done && m_rsp == 2'd3, "R4", m_rsp, 3);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule